// File: doc/BRIEF.md
# Sample Clock Phase Tuning Engine

The engine searches for the receive sampling phase of a card interface that sits furthest from failure. A start strobe launches a sweep over `NUM_PHASES` phase indices. For every index the engine raises a request carrying that index to an external command engine. That engine runs a tuning transfer and answers with an acknowledge and a pass or fail verdict. Failing indices are skipped past in steps of about twenty degrees, because failed transfers are slow. The final index is always tried.

While the sweep runs, the engine records the passing windows. It keeps only three of them: the first window, the window in progress and the best window between the two. The windows are treated as circular, so a window that touches the last index and one that touches index zero count as a single window. At the end the engine converts the centre of the longest window into degrees and presents it. If every index passed, it presents a configured default phase instead. If no index passed, it flags an error and keeps the phase it held before. The clocks, the delay lines and the tuning command frames are built elsewhere.

Top module: `phase_tune_engine`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `phaseReq` are low and `phaseDeg` equals the `DEFAULT_DEG` parameter.
- R2: Only one request is made per tested index. `phaseReq` stays high and `phaseIdx` stays stable until `testAck` is sampled high. `phaseReq` is low in the cycle after the acknowledge.
- R3: The sweep starts at index 0. After a pass, the next index is i+1. After a fail at an index below N-1, the next index is i+ceil(20*N/360), clamped to N-1. The sweep ends once index N-1 has been tested, whatever its result.
- R4: A passing window opens at a passing index whose previously tested index failed. The state before the first test counts as failed. Each further passing index extends the window's end, and the window's length is end-start+1.
- R5: If there are two or more windows and both index 0 and index N-1 passed, the last window and the first window merge into one window. It starts at the last window's start and ends at the first window's end. Its length is end-start+1+N.
- R6: Windows are compared in order: the first (or merged) window, then the later ones. A window replaces the best so far only when it is strictly longer, so the earliest of equal windows is chosen.
- R7: The chosen index is (start + length/2) mod N, with integer division. `phaseDeg` becomes ceil(index*360/N).
- R8: If the only window runs from index 0 to index N-1, `phaseDeg` becomes `DEFAULT_DEG`.
- R9: If no index passes, `error` rises together with `done` and `phaseDeg` keeps its previous value. A successful sweep leaves `error` low.
- R10: `busy` is high from the cycle after an accepted start until the result is presented, and `done` is low while `busy` is high. `done` stays high until the next start. A start that arrives while `busy` is high is ignored and does not restart the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that launches a sweep when idle |
| phaseReq | output | 1 | Request to the tester to run a transfer at `phaseIdx` |
| phaseIdx | output | IDX_W | Phase index under test |
| testAck | input | 1 | Tester has finished the transfer for the current index |
| testPass | input | 1 | Verdict that comes with `testAck`, 1 meaning pass |
| busy | output | 1 | Sweep or result selection in progress |
| done | output | 1 | Result presented; held until the next start |
| error | output | 1 | The last sweep found no passing index |
| phaseDeg | output | 9 | Selected sampling phase in degrees, 0 to 359 |

## Verification
A wrong window register in this engine usually stays hidden until the sweep ends. It then appears on `phaseDeg` in the cycle after the final acknowledge, as a phase that is off by part of a window or that points at the wrong window. A wrong step or clamp shows much sooner: the index presented with the next request already differs from the one the pass and fail pattern implies. Each sweep is therefore judged twice, once on the order of the indices it requests and once on the phase, error and done values it ends with. The pass patterns are chosen so that window edges fall on and off the skip grid, windows tie in length, windows wrap around index zero and the centre itself wraps around.

// File: rtl/tune_pkg.sv
package tune_pkg;

  // Strobes from the sequencer to the window datapath, one cycle each.
  typedef struct packed {
    logic init;     // clear window state and begin at index 0
    logic capture;  // a verdict for phaseIdx is on testPass
    logic finish;   // pick the best window and present the result
  } tuneStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_GAP  = 2'd2,
    ST_FIN  = 2'd3
  } tuneState_t;

endpackage

// File: rtl/tune_ctrl.sv
module tune_ctrl
  import tune_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        testAck,
  input  logic        lastIdx,
  output logic        phaseReq,
  output logic        busy,
  output tuneStrobe_t strb
);

  tuneState_t state, stateNext;

  always_comb begin
    stateNext    = state;
    strb         = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.init = 1'b1;
          stateNext = ST_ASK;
        end
      end
      ST_ASK: begin
        if (testAck) begin
          strb.capture = 1'b1;
          stateNext    = lastIdx ? ST_FIN : ST_GAP;
        end
      end
      ST_GAP:  stateNext = ST_ASK;
      ST_FIN: begin
        strb.finish = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign phaseReq = (state == ST_ASK);
  assign busy     = (state != ST_IDLE);

  // R2: the request drops right after it is acknowledged
  a_r2_req_drop: assert property (@(posedge clk) disable iff (!rstN)
    phaseReq && testAck |=> !phaseReq);

endmodule

// File: rtl/tune_dp.sv
module tune_dp
  import tune_pkg::*;
#(
  parameter int NUM_PHASES  = 360,
  parameter int DEFAULT_DEG = 0,
  parameter int IDX_W       = $clog2(NUM_PHASES)
)(
  input  logic             clk,
  input  logic             rstN,
  input  tuneStrobe_t      strb,
  input  logic             testPass,
  output logic [IDX_W-1:0] phaseIdx,
  output logic             lastIdx,
  output logic [8:0]       phaseDeg,
  output logic             done,
  output logic             error
);

  localparam int WW   = IDX_W + 2;
  localparam int SKIP = (20 * NUM_PHASES + 359) / 360;
  localparam int DW   = $clog2(NUM_PHASES * 360 + NUM_PHASES) + 2;
  localparam logic [WW-1:0] LAST_W = WW'(NUM_PHASES - 1);
  localparam logic [WW-1:0] N_W    = WW'(NUM_PHASES);

  // sweep state
  logic [WW-1:0] idx;
  logic          prevPass, firstPass, lastPass;
  logic [1:0]    winCnt;           // 0, 1, or 2 meaning two or more
  logic [WW-1:0] firstStart, firstEnd;
  logic [WW-1:0] curStart, curEnd;
  logic          midValid;
  logic [WW-1:0] midStart, midLen;

  assign phaseIdx = IDX_W'(idx);
  assign lastIdx  = (idx == LAST_W);

  // next index after a verdict
  logic [WW-1:0] skipSum, nextIdx;
  always_comb begin
    skipSum = idx + WW'(SKIP);
    if (testPass)            nextIdx = idx + WW'(1);
    else if (skipSum > LAST_W) nextIdx = LAST_W;
    else                     nextIdx = skipSum;
  end

  logic          opens;
  logic [WW-1:0] curLen, firstLen, mergedLen;
  assign opens     = testPass && !prevPass;
  assign curLen    = curEnd - curStart + WW'(1);
  assign firstLen  = firstEnd - firstStart + WW'(1);
  assign mergedLen = firstEnd + WW'(1) + N_W - curStart;

  // result selection
  logic          doMerge, allPass;
  logic [WW-1:0] bestStart, bestLen, centreRaw, centre;
  logic [DW-1:0] degProd, degFull;

  always_comb begin
    doMerge = (winCnt == 2'd2) && firstPass && lastPass;
    allPass = (winCnt == 2'd1) && (firstStart == '0) && (firstEnd == LAST_W);
    if (doMerge) begin
      bestStart = curStart;
      bestLen   = mergedLen;
      if (midValid && (midLen > bestLen)) begin
        bestStart = midStart;
        bestLen   = midLen;
      end
    end else begin
      bestStart = firstStart;
      bestLen   = firstLen;
      if (winCnt == 2'd2) begin
        if (midValid && (midLen > bestLen)) begin
          bestStart = midStart;
          bestLen   = midLen;
        end
        if (curLen > bestLen) begin
          bestStart = curStart;
          bestLen   = curLen;
        end
      end
    end
    centreRaw = bestStart + (bestLen >> 1);
    centre    = (centreRaw >= N_W) ? (centreRaw - N_W) : centreRaw;
    degProd   = DW'(centre) * DW'(360) + DW'(NUM_PHASES - 1);
    degFull   = degProd / DW'(NUM_PHASES);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx        <= '0;
      prevPass   <= 1'b0;
      firstPass  <= 1'b0;
      lastPass   <= 1'b0;
      winCnt     <= 2'd0;
      firstStart <= '0;
      firstEnd   <= '0;
      curStart   <= '0;
      curEnd     <= '0;
      midValid   <= 1'b0;
      midStart   <= '0;
      midLen     <= '0;
      phaseDeg   <= 9'(DEFAULT_DEG);
      done       <= 1'b0;
      error      <= 1'b0;
    end else if (strb.init) begin
      idx       <= '0;
      prevPass  <= 1'b0;
      firstPass <= 1'b0;
      lastPass  <= 1'b0;
      winCnt    <= 2'd0;
      midValid  <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else if (strb.capture) begin
      prevPass <= testPass;
      lastPass <= testPass;
      if (idx == '0) firstPass <= testPass;
      if (opens) begin
        // the window in progress is a middle one once two or more exist
        if ((winCnt == 2'd2) && (!midValid || (curLen > midLen))) begin
          midValid <= 1'b1;
          midStart <= curStart;
          midLen   <= curLen;
        end
        curStart <= idx;
        curEnd   <= idx;
        if (winCnt == 2'd0) begin
          firstStart <= idx;
          firstEnd   <= idx;
        end
        if (winCnt != 2'd2) winCnt <= winCnt + 2'd1;
      end else if (testPass) begin
        curEnd <= idx;
        if (winCnt == 2'd1) firstEnd <= idx;
      end
      if (!lastIdx) idx <= nextIdx;
    end else if (strb.finish) begin
      done <= 1'b1;
      if (winCnt == 2'd0)  error    <= 1'b1;
      else if (allPass)    phaseDeg <= 9'(DEFAULT_DEG);
      else                 phaseDeg <= 9'(degFull);
    end
  end

  // R9: a failed sweep leaves the presented phase untouched
  a_r9_err_keeps_phase: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> $stable(phaseDeg));

  // R7: the presented phase is always a legal angle
  a_r7_deg_range: assert property (@(posedge clk) disable iff (!rstN)
    phaseDeg < 9'd360);

  // R4: windows never end before they start
  a_r4_win_order: assert property (@(posedge clk) disable iff (!rstN)
    (winCnt != 2'd0) |-> (curEnd >= curStart) && (firstEnd >= firstStart));

  // R3: the index never leaves the phase range
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    idx <= LAST_W);

endmodule

// File: rtl/phase_tune_engine.sv
module phase_tune_engine
  import tune_pkg::*;
#(
  parameter int NUM_PHASES  = 360,
  parameter int DEFAULT_DEG = 0,
  parameter int IDX_W       = $clog2(NUM_PHASES)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             phaseReq,
  output logic [IDX_W-1:0] phaseIdx,
  input  logic             testAck,
  input  logic             testPass,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [8:0]       phaseDeg
);

  tuneStrobe_t strb;
  logic        lastIdx;

  tune_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .testAck  (testAck),
    .lastIdx  (lastIdx),
    .phaseReq (phaseReq),
    .busy     (busy),
    .strb     (strb)
  );

  tune_dp #(
    .NUM_PHASES  (NUM_PHASES),
    .DEFAULT_DEG (DEFAULT_DEG),
    .IDX_W       (IDX_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .testPass (testPass),
    .phaseIdx (phaseIdx),
    .lastIdx  (lastIdx),
    .phaseDeg (phaseDeg),
    .done     (done),
    .error    (error)
  );

  // R2: index held while the tester has not answered
  a_r2_idx_stable: assert property (@(posedge clk) disable iff (!rstN)
    phaseReq && !testAck |=> $stable(phaseIdx));

  // R10: a result is never flagged while a sweep is running
  a_r10_busy_no_done: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

endmodule

// File: tb/phase_tune_engine_tb_top.sv
module phase_tune_engine_tb_top;

  localparam int N    = 100;
  localparam int DEF  = 45;
  localparam int IW   = $clog2(N);
  localparam int SKIP = (20 * N + 359) / 360;

  typedef struct packed {
    int lo1; int hi1; int lo2; int hi2; int lo3; int hi3;
    bit expErr; int expDeg; int ackDly; bit restart;
  } vec_t;

  // pass windows (lo>hi = none), expected error, expected degrees
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{30, 59, -1, -2, -1, -2, 1'b0, 162, 0, 1'b0}, // R4 R7 aligned window
    '{-1, -2, -1, -2, -1, -2, 1'b1, 162, 0, 1'b0}, // R9 nothing passes
    '{33, 50, -1, -2, -1, -2, 1'b0, 155, 0, 1'b0}, // R3 edge off skip grid
    '{ 0,  9, 80, 99, -1, -2, 1'b0, 346, 0, 1'b0}, // R5 circular merge
    '{12, 21, 40, 49, -1, -2, 1'b0,  62, 3, 1'b0}, // R6 tie, slow tester
    '{12, 17, 36, 59, -1, -2, 1'b0, 173, 0, 1'b1}, // R6 later longer, restart
    '{ 0, 99, -1, -2, -1, -2, 1'b0,  45, 0, 1'b0}, // R8 all pass
    '{ 0,  4, 30, 69, 90, 99, 1'b0, 188, 0, 1'b0}, // R5 R6 middle beats merge
    '{ 0, 19, 40, 45, 70, 99, 1'b0, 342, 0, 1'b0}, // R5 merge beats middle
    '{99, 99, -1, -2, -1, -2, 1'b0, 357, 0, 1'b0}, // R3 only last index
    '{ 0,  0, 99, 99, -1, -2, 1'b0,   0, 0, 1'b0}, // R7 centre wraps
    '{ 0, 49, -1, -2, -1, -2, 1'b0,  90, 0, 1'b0}  // R8 start 0 not full
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          phaseReq;
  logic [IW-1:0] phaseIdx;
  logic          testAck = 1'b0;
  logic          testPass = 1'b0;
  logic          busy, done, error;
  logic [8:0]    phaseDeg;

  always #2 clk = ~clk;

  phase_tune_engine #(.NUM_PHASES(N), .DEFAULT_DEG(DEF)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .phaseReq(phaseReq),
    .phaseIdx(phaseIdx), .testAck(testAck), .testPass(testPass),
    .busy(busy), .done(done), .error(error), .phaseDeg(phaseDeg)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // tester model
  vec_t cur;
  int   expIdx = 0, seqErr = 0, stabErr = 0, waitCnt = 0, reqIdx = 0;
  bit   inReq = 0;

  function automatic bit inMask(input int i);
    return (i >= cur.lo1 && i <= cur.hi1) || (i >= cur.lo2 && i <= cur.hi2) ||
           (i >= cur.lo3 && i <= cur.hi3);
  endfunction

  always @(negedge clk) begin
    if (phaseReq && !testAck) begin
      if (!inReq) begin
        inReq   = 1'b1;
        waitCnt = 0;
        reqIdx  = int'(phaseIdx);
        if (int'(phaseIdx) != expIdx) seqErr++;
      end else if (int'(phaseIdx) != reqIdx) begin
        stabErr++;
      end
      if (waitCnt >= cur.ackDly) begin
        testAck  = 1'b1;
        testPass = inMask(int'(phaseIdx));
        inReq    = 1'b0;
        if (testPass) expIdx = int'(phaseIdx) + 1;
        else expIdx = (int'(phaseIdx) + SKIP > N - 1) ? N - 1 : int'(phaseIdx) + SKIP;
      end else begin
        waitCnt++;
      end
    end else begin
      testAck  = 1'b0;
      testPass = 1'b0;
    end
  end

  task automatic runVec(input int v);
    int guard;
    cur = VECS[v];
    expIdx = 0; seqErr = 0; stabErr = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done && !error, "R10 busy set, done cleared on start", {busy, done, error}, 3'b100);
    if (cur.restart) begin
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R10 start while busy ignored", busy, 1);
    end
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(done == 1'b1, "R10 done after sweep", done, 1);
    check(busy == 1'b0, "R10 busy low with result", busy, 0);
    check(seqErr == 0, "R3 index order (R10 restart)", seqErr, 0);
    check(stabErr == 0, "R2 index stable while waiting", stabErr, 0);
    check(error == cur.expErr, "R9 error flag", error, cur.expErr);
    check(int'(phaseDeg) == cur.expDeg, "R4/R5/R6/R7/R8 phase", phaseDeg, cur.expDeg);
    repeat (3) @(negedge clk);
    check(done == 1'b1 && int'(phaseDeg) == cur.expDeg, "R10 result held", phaseDeg, cur.expDeg);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    cur = VECS[0];
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !error && !phaseReq, "R1 flags after reset",
          {busy, done, error, phaseReq}, 0);
    check(int'(phaseDeg) == DEF, "R1 default phase after reset", phaseDeg, DEF);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !phaseReq, "R1 idle without start", {busy, phaseReq}, 0);
    for (int v = 0; v < NV; v++) runVec(v);
    // R2 request drops once acknowledged: a fresh sweep then idle
    cur = VECS[0];
    expIdx = 0; seqErr = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(phaseReq && int'(phaseIdx) == 0, "R2 R3 first request at index 0", phaseIdx, 0);
    @(negedge clk);
    check(!phaseReq, "R2 request low after ack", phaseReq, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule